// File: doc/BRIEF.md
# PLL Bandwidth Mode Control Register

This block is a single byte-wide register on a simple CPU bus that governs how a PLL chooses its loop bandwidth. Software selects between automatic bandwidth control, where an external sequencer decides between the wide-band acquisition mode and the narrow-band tracking mode, and manual control, where software picks the mode itself. The block drives the effective mode and the automatic-enable signal to the PLL. It also reads back the lock status and the sequencer's mode while automatic control is on.

The mode bit changes how it can be accessed depending on the control mode. Under manual control it is a plain read/write bit. Under automatic control it reads back the sequencer's status and ignores writes. The value software chose manually is kept aside while automatic control runs, and it becomes the effective mode again when manual control resumes. A fourth bit is a spare read/write flag tied to crystal-loss detection, with no side effects. The lock detector, the sequencer and the analog loop are outside the block and reach it only as status inputs.

Reset is asserted asynchronously and released through a synchronizer, so the register leaves reset a few clock edges after `rst_n` rises. Writes take effect on the rising clock edge. Reads are combinational.

Top module: `pll_bw_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `auto_en` is 0 and `bw_track` is 0, which means acquisition mode under manual control.
- R2: Bit 7 is the automatic-control select and can be read and written. When it is 1, `auto_en` is 1 and control is automatic. When it is 0, control is manual.
- R3: Under manual control, bit 5 can be read and written and selects the mode, 1 for tracking and 0 for acquisition. `bw_track` equals the stored manual value.
- R4: Bit 6 reads the `pll_locked` input while control is automatic, and reads 0 while control is manual.
- R5: While control is automatic, bit 5 reads the `auto_trk` input and `bw_track` equals `auto_trk`.
- R6: While control is automatic, writes to bits 5 and 6 are ignored. The stored manual mode is kept and drives `bw_track` again once control returns to manual.
- R7: A write is interpreted using bit 7 as it was before the write. A write that sets bit 7 while control is manual also stores its bit 5 as the manual mode. A write that clears bit 7 while control is automatic ignores its bit 5.
- R8: Bit 4 is a plain read/write storage bit with no effect on any other output.
- R9: Bits 3 to 0 always read 0 and ignore writes. Writes to any address other than 0x39 change nothing. Reads are valid only when the bus selects address 0x39, and otherwise return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when the register is not addressed |
| pll_locked | input | 1 | Lock status from the lock detector |
| auto_trk | input | 1 | Sequencer mode, 1 for tracking |
| auto_en | output | 1 | Automatic bandwidth control enabled |
| bw_track | output | 1 | Effective bandwidth mode, 1 for tracking |

## Verification
The bench sweeps every write value under each combination of the two status inputs while the control mode moves between manual and automatic. This exposes a design that decodes a write with the new value of bit 7 instead of the old one. Such a design would either store bit 5 of a write that clears bit 7, or drop bit 5 of a write that sets it. The bench also checks that a manual value written before automatic control survives writes to bit 5 made during automatic control. A design that shares one flop between the stored and the reported mode loses that value. Further checks confirm that bit 6 reads 0 under manual control even while `pll_locked` is high, and that writes to a wrong address do not alter the register.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned BIT_AUTO = 7;
  localparam int unsigned BIT_LOCK = 6;
  localparam int unsigned BIT_TRK  = 5;
  localparam int unsigned BIT_XTL  = 4;
  localparam int unsigned LOW_IMPL = 4;   // bits below this are unimplemented

  typedef struct packed {
    logic auto_on;
    logic man_trk;
    logic xtl;
  } pbw_state_t;

  typedef struct packed {
    logic auto_on;
    logic trk;
    logic xtl;
  } pbw_wfields_t;
endpackage

// File: rtl/pbw_rst_sync.sv
module pbw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pbw_bus_decode.sv
module pbw_bus_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h39
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic addr_match;

  always_comb begin
    addr_match = (bus_addr == REG_ADDR);
    wr_hit     = bus_sel && bus_wr && addr_match;
    rd_hit     = bus_sel && !bus_wr && addr_match;
  end
endmodule

// File: rtl/pbw_mode_store.sv
module pbw_mode_store
  import pbw_pkg::*;
(
  input  logic         clk,
  input  logic         srst_n,
  input  logic         wr_hit,
  input  pbw_wfields_t wf,
  output pbw_state_t   state_q
);
  pbw_state_t state_d;
  logic       state_en;

  // Next state: the write is decoded against the control mode held before it.
  always_comb begin
    state_en         = wr_hit;
    state_d          = state_q;
    state_d.auto_on  = wf.auto_on;
    state_d.xtl      = wf.xtl;
    if (!state_q.auto_on) state_d.man_trk = wf.trk;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  // R6: saved manual mode cannot move while automatic control persists
  a_r6_manual_held: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q.auto_on && $past(state_q.auto_on)) |-> $stable(state_q.man_trk));

  // R3: a manual-mode write stores bit 5
  a_r3_manual_write: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_hit && !state_q.auto_on) |=> (state_q.man_trk == $past(wf.trk)));

  // R7: a write that leaves automatic control restores, not overwrites
  a_r7_clear_restore: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_hit && state_q.auto_on && !wf.auto_on) |=> (!state_q.auto_on && $stable(state_q.man_trk)));

  // R8: the spare bit follows every accepted write
  a_r8_spare_rw: assert property (@(posedge clk) disable iff (!srst_n)
    wr_hit |=> (state_q.xtl == $past(wf.xtl)));
endmodule

// File: rtl/pbw_readback.sv
module pbw_readback
  import pbw_pkg::*;
(
  input  logic             rd_hit,
  input  pbw_state_t       state_q,
  input  logic             pll_locked,
  input  logic             auto_trk,
  output logic [REG_W-1:0] rdata,
  output logic             bw_track
);
  logic [REG_W-1:0] image;

  always_comb begin
    bw_track = state_q.auto_on ? auto_trk : state_q.man_trk;
  end

  always_comb begin
    image[BIT_AUTO] = state_q.auto_on;
    image[BIT_LOCK] = state_q.auto_on && pll_locked;
    image[BIT_TRK]  = bw_track;
    image[BIT_XTL]  = state_q.xtl;
  end

  genvar gi;
  generate
    for (gi = 0; gi < LOW_IMPL; gi++) begin : g_unimpl
      assign image[gi] = 1'b0;
    end
  endgenerate

  always_comb begin
    rdata = rd_hit ? image : '0;
  end
endmodule

// File: rtl/pll_bw_ctrl.sv
module pll_bw_ctrl
  import pbw_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h39,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              pll_locked,
  input  logic              auto_trk,
  output logic              auto_en,
  output logic              bw_track
);
  logic         srst_n;
  logic         wr_hit;
  logic         rd_hit;
  pbw_wfields_t wf;
  pbw_state_t   state_q;
  logic         unused_wbits;

  pbw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  pbw_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  always_comb begin
    wf.auto_on   = bus_wdata[BIT_AUTO];
    wf.trk       = bus_wdata[BIT_TRK];
    wf.xtl       = bus_wdata[BIT_XTL];
    unused_wbits = ^{bus_wdata[BIT_LOCK], bus_wdata[LOW_IMPL-1:0]};
  end

  pbw_mode_store u_store (
    .clk(clk), .srst_n(srst_n), .wr_hit(wr_hit), .wf(wf), .state_q(state_q)
  );

  pbw_readback u_rb (
    .rd_hit(rd_hit), .state_q(state_q), .pll_locked(pll_locked),
    .auto_trk(auto_trk), .rdata(bus_rdata), .bw_track(bw_track)
  );

  assign auto_en = state_q.auto_on;

  // R5: automatic control hands the mode to the sequencer
  a_r5_auto_follow: assert property (@(posedge clk) disable iff (!srst_n)
    auto_en |-> (bw_track == auto_trk));

  // R4: lock reads zero under manual control
  a_r4_lock_manual: assert property (@(posedge clk) disable iff (!srst_n)
    !auto_en |-> !bus_rdata[BIT_LOCK]);

  // R9: unimplemented bits never read as one
  a_r9_low_zero: assert property (@(posedge clk) disable iff (!srst_n)
    bus_rdata[LOW_IMPL-1:0] == '0);

  // R2: a write to bit 7 sets the automatic enable
  a_r2_auto_write: assert property (@(posedge clk) disable iff (!srst_n)
    wr_hit |=> (auto_en == $past(bus_wdata[BIT_AUTO])));
endmodule

// File: tb/tb_pll_bw_ctrl.sv
module tb_pll_bw_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       pll_locked = 1'b0, auto_trk = 1'b0;
  logic       auto_en, bw_track;

  int checks = 0;
  int failures = 0;
  logic m_auto = 1'b0, m_man = 1'b0, m_xtl = 1'b0;

  always #2 clk = ~clk;

  pll_bw_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pll_locked(pll_locked), .auto_trk(auto_trk),
    .auto_en(auto_en), .bw_track(bw_track)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_img();
    exp_img = {m_auto, m_auto & pll_locked, (m_auto ? auto_trk : m_man), m_xtl, 4'b0000};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (a == 8'h39) begin
      if (!m_auto) m_man = d[5];
      m_auto = d[7];
      m_xtl  = d[4];
    end
  endtask

  task automatic rd(output logic [7:0] v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h39;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    rd(v);
    chk(req, v, exp_img());
    chk(req, {7'b0, auto_en}, {7'b0, m_auto});
    chk(req, {7'b0, bw_track}, {7'b0, (m_auto ? auto_trk : m_man)});
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, with status inputs high to expose leaks
    pll_locked = 1'b1; auto_trk = 1'b1;
    rd(v);
    chk("R1", v, 8'h00);
    chk("R1", {6'b0, auto_en, bw_track}, 8'h00);

    // R3 manual write of tracking, R4 lock masked in manual
    wr(8'h39, 8'h20);
    check_all("R3");
    rd(v); chk("R4", {7'b0, v[6]}, 8'h00);

    // R2 enter auto with bit5=0: saved manual becomes 0 (R7)
    wr(8'h39, 8'h80);
    check_all("R2");
    auto_trk = 1'b0; check_all("R5");
    pll_locked = 1'b0; check_all("R4");
    // R6 writes to bits 6/5 in auto ignored
    wr(8'h39, 8'hE0);
    check_all("R6");
    // R7 clear auto with bit5=1: bit 5 ignored, restore 0
    wr(8'h39, 8'h20);
    check_all("R7");
    chk("R7", {7'b0, bw_track}, 8'h00);

    // R7 set auto from manual with bit5=1: stored as manual
    wr(8'h39, 8'hA0);
    auto_trk = 1'b0;
    check_all("R5");
    wr(8'h39, 8'h80);   // R6: attempt to clear in auto is ignored
    wr(8'h39, 8'h00);
    check_all("R6");
    chk("R6", {7'b0, bw_track}, 8'h01);

    // R8 spare bit
    wr(8'h39, 8'h10); check_all("R8");
    wr(8'h39, 8'h00); check_all("R8");

    // R9 wrong address and low bits
    wr(8'h38, 8'hFF); check_all("R9");
    wr(8'h39, 8'h0F); check_all("R9");
    bus_sel = 1'b0; bus_addr = 8'h39; #1 chk("R9", bus_rdata, 8'h00);
    bus_sel = 1'b1; bus_addr = 8'h3A; #1 chk("R9", bus_rdata, 8'h00);
    bus_sel = 1'b0;

    // Sweep: every write value under every status pair, R2 through R9
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 256; d++) begin
        pll_locked = s[0]; auto_trk = s[1];
        wr(8'h39, d[7:0]);
        check_all("R7_sweep");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule